// File: doc/BRIEF.md
# BCD-Capable Accumulator Adder

This block is the arithmetic core that sits beside an accumulator. Each cycle it may take the current accumulator value, an operand and the incoming carry and auxiliary-carry flags, and produce a new accumulator value and new flags. It supports three operations: a binary add, a binary add that also adds the incoming carry, and a decimal adjust. The decimal adjust turns the result of a binary add of two packed-BCD numbers into packed BCD.

The result is registered, so it appears one clock after the operation is issued. While no operation is issued, the result registers keep their values. The width is set by the number of 4-bit digits, and the default is two digits (8 bits). The auxiliary carry is always the carry out of the lowest digit. The main carry is always the carry out of the top bit.

The decimal adjust corrects each digit in turn, from the lowest upward. The lowest digit uses the auxiliary carry, and the top digit uses the carry. A correction carry from a lower digit ripples into the next digit before that digit is tested.

Top module: `accum_bcd_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc_q`, `cy_q` and `ac_q` are all zero until the first issued operation.
- R2: Operation code 2'b00 (add): one clock after `op_valid` is high, `acc_q` holds (`acc_in` + `opnd_in`) modulo 2^W. The `cy_in` input has no effect on any output.
- R3: For codes 2'b00 and 2'b01, `cy_q` is the carry out of bit W-1 of that operation's sum.
- R4: For codes 2'b00 and 2'b01, `ac_q` is the carry out of bit 3 of the same sum, including the added carry for code 2'b01.
- R5: Operation code 2'b01 (add with carry): `acc_q` holds (`acc_in` + `opnd_in` + `cy_in`) modulo 2^W.
- R6: Operation code 2'b10 (decimal adjust), lowest digit: 6 is added to bits 3:0 of `acc_in` when they exceed 9 or `ac_in` is 1. The carry of this addition enters the next digit. A carry out of the top digit from this step is discarded.
- R7: Decimal adjust, top digit: it is tested after the lower corrections have rippled in. 6 is added to it when it exceeds 9 or `cy_in` is 1. `cy_q` is 1 exactly when this top-digit addition overflows, and 0 otherwise. An overflowing correction therefore leaves that digit below 6.
- R8: Decimal adjust leaves `opnd_in` unused, and `ac_q` takes the value of `ac_in`.
- R9: When `op_valid` is low, or the code is 2'b11, all three outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Issue strobe; the selected operation is performed this cycle |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 decimal adjust, 11 no operation |
| acc_in | input | W | Current accumulator value |
| opnd_in | input | W | Operand for the two add operations |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| acc_q | output | W | Registered new accumulator value |
| cy_q | output | 1 | Registered new carry flag |
| ac_q | output | 1 | Registered new auxiliary-carry flag |

## Verification
The bench builds the block with the default of two digits. At that width the whole space of accumulator and operand pairs for the plain add (65,536 pairs) can be covered exhaustively within the cycle budget. The add with carry is swept over every accumulator value against a spread of operands, with both carry values. Every pair of two-digit BCD values is added and then decimal adjusted, so every combination of digit overflow, auxiliary carry and carry that a BCD add can produce reaches the adjust logic.

// File: rtl/accadd_pkg.sv
package accadd_pkg;
  localparam int NIB = 4;
  localparam logic [3:0] BCD_MAX = 4'd9;
  localparam logic [3:0] BCD_FIX = 4'd6;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'b00,
    OPC_ADDC = 2'b01,
    OPC_DADJ = 2'b10,
    OPC_NOP  = 2'b11
  } opc_e;
endpackage

// File: rtl/nibble_add.sv
module nibble_add
  import accadd_pkg::*;
(
  input  logic [NIB-1:0] a_i,
  input  logic [NIB-1:0] b_i,
  input  logic           cin_i,
  output logic [NIB-1:0] sum_o,
  output logic           cout_o
);
  logic [NIB:0] total;

  assign total  = {1'b0, a_i} + {1'b0, b_i} + {{NIB{1'b0}}, cin_i};
  assign sum_o  = total[NIB-1:0];
  assign cout_o = total[NIB];
endmodule

// File: rtl/nib_ripple_add.sv
module nib_ripple_add
  import accadd_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int W      = DIGITS * NIB
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         aux_o,
  output logic         cout_o
);
  logic [DIGITS:0] chain;

  assign chain[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    nibble_add u_nib (
      .a_i   (a_i[g*NIB +: NIB]),
      .b_i   (b_i[g*NIB +: NIB]),
      .cin_i (chain[g]),
      .sum_o (sum_o[g*NIB +: NIB]),
      .cout_o(chain[g+1])
    );
  end

  assign aux_o  = chain[1];
  assign cout_o = chain[DIGITS];
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import accadd_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int W      = DIGITS * NIB
) (
  input  logic [W-1:0] val_i,
  input  logic         aux_i,
  input  logic         cy_i,
  output logic [W-1:0] val_o,
  output logic         cy_o
);
  // prop[g]: carry entering digit g from the digit below
  logic [DIGITS-1:0] prop;

  assign prop[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic           flag;
    logic [NIB-1:0] pre;
    logic [NIB:0]   fixed;

    assign flag = ((g == 0) ? aux_i : 1'b0) | ((g == DIGITS - 1) ? cy_i : 1'b0);

    if (g == DIGITS - 1) begin : g_top
      // top digit: ripple-in overflow is dropped; only the correction counts
      assign pre  = val_i[g*NIB +: NIB] + {{(NIB-1){1'b0}}, prop[g]};
      assign cy_o = fixed[NIB];
    end else begin : g_low
      logic [NIB:0] wide;
      assign wide        = {1'b0, val_i[g*NIB +: NIB]} + {{NIB{1'b0}}, prop[g]};
      assign pre         = wide[NIB-1:0];
      assign prop[g+1]   = wide[NIB] | fixed[NIB];
    end

    assign fixed = {1'b0, pre} + (((pre > BCD_MAX) || flag) ? {1'b0, BCD_FIX} : '0);
    assign val_o[g*NIB +: NIB] = fixed[NIB-1:0];
  end
endmodule

// File: rtl/accum_bcd_alu.sv
module accum_bcd_alu
  import accadd_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int W      = DIGITS * NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] acc_q,
  output logic         cy_q,
  output logic         ac_q
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  opc_e opc;
  assign opc = opc_e'(op_sel);

  // binary path
  logic [W-1:0] bin_sum;
  logic         bin_aux, bin_cy, bin_cin;

  assign bin_cin = (opc == OPC_ADDC) & cy_in;

  nib_ripple_add #(.DIGITS(DIGITS)) u_add (
    .a_i   (acc_in),
    .b_i   (opnd_in),
    .cin_i (bin_cin),
    .sum_o (bin_sum),
    .aux_o (bin_aux),
    .cout_o(bin_cy)
  );

  // decimal path
  logic [W-1:0] da_val;
  logic         da_cy;

  bcd_adjust #(.DIGITS(DIGITS)) u_da (
    .val_i(acc_in),
    .aux_i(ac_in),
    .cy_i (cy_in),
    .val_o(da_val),
    .cy_o (da_cy)
  );

  // next state
  logic [W-1:0] acc_d;
  logic         cy_d, ac_d, load;

  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    ac_d  = ac_q;
    load  = op_valid && (opc != OPC_NOP);
    case (opc)
      OPC_ADD, OPC_ADDC: begin
        acc_d = bin_sum;
        cy_d  = bin_cy;
        ac_d  = bin_aux;
      end
      OPC_DADJ: begin
        acc_d = da_val;
        cy_d  = da_cy;
        ac_d  = ac_in;
      end
      default: ;
    endcase
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
    end else if (load) begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
      ac_q  <= ac_d;
    end
  end

  // checks against the port-level arithmetic
  assert_add_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && opc == OPC_ADD) |=>
      ({cy_q, acc_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)})));

  assert_addc_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && opc == OPC_ADDC) |=>
      ({cy_q, acc_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                         + {{W{1'b0}}, $past(cy_in)})));

  assert_aux_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && (opc == OPC_ADD || opc == OPC_ADDC)) |=>
      (ac_q == (({1'b0, $past(acc_in[NIB-1:0])} + {1'b0, $past(opnd_in[NIB-1:0])}
                 + {{NIB{1'b0}}, $past(op_sel == 2'b01 && cy_in)}) > 5'd15)));

  assert_da_aux_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && opc == OPC_DADJ) |=> (ac_q == $past(ac_in)));

  assert_da_wrap_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && opc == OPC_DADJ) |=> (!cy_q || (acc_q[W-1 -: NIB] < BCD_FIX)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(op_valid && opc != OPC_NOP) |=> ($stable(acc_q) && $stable(cy_q) && $stable(ac_q)));
endmodule

// File: tb/test_accum_bcd_alu.sv
module test_accum_bcd_alu;
  localparam int DIGITS = 2;
  localparam int W      = DIGITS * 4;
  localparam int LIMIT  = 190000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid;
  logic [1:0]   op_sel;
  logic [W-1:0] acc_in, opnd_in;
  logic         cy_in, ac_in;
  logic [W-1:0] acc_q;
  logic         cy_q, ac_q;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  accum_bcd_alu #(.DIGITS(DIGITS)) i_accum_bcd_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
    .acc_q(acc_q), .cy_q(cy_q), .ac_q(ac_q)
  );

  // {op, acc, opnd, cy, ac, exp_acc, exp_cy, exp_ac}
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {2'b00, 8'h3A, 8'h26, 1'b1, 1'b0, 8'h60, 1'b0, 1'b1},
    {2'b00, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'b00, 8'h80, 8'h80, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0},
    {2'b01, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1},
    {2'b01, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1},
    {2'b01, 8'h12, 8'h34, 1'b0, 1'b1, 8'h46, 1'b0, 1'b0},
    {2'b10, 8'h0A, 8'h55, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},
    {2'b10, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {2'b10, 8'h32, 8'h00, 1'b1, 1'b1, 8'h98, 1'b0, 1'b1},
    {2'b10, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0},
    {2'b10, 8'h45, 8'hFF, 1'b0, 1'b0, 8'h45, 1'b0, 1'b0},
    {2'b10, 8'hA0, 8'h00, 1'b0, 1'b1, 8'h06, 1'b1, 1'b1},
    {2'b10, 8'h99, 8'h00, 1'b1, 1'b0, 8'hF9, 1'b0, 1'b0}
  };

  function automatic logic [9:0] model(input logic [1:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic c, input logic h);
    int t, lo, ncy;
    model = 10'h0;
    if (op == 2'b00 || op == 2'b01) begin
      t  = int'(a) + int'(b) + ((op == 2'b01) ? int'(c) : 0);
      lo = int'(a % 16) + int'(b % 16) + ((op == 2'b01) ? int'(c) : 0);
      model = {8'(t % 256), (t > 255), (lo > 15)};
    end else if (op == 2'b10) begin
      t = int'(a);
      if ((t % 16) > 9 || h) t = (t + 6) % 256;
      ncy = 0;
      if ((t / 16) > 9 || c) begin
        t = t + 96;
        ncy = (t > 255) ? 1 : 0;
      end
      model = {8'(t % 256), ncy[0], h};
    end
  endfunction

  task automatic chk(input string req, input logic [9:0] exp);
    n_chk++;
    if ({acc_q, cy_q, ac_q} !== exp) begin
      n_err++;
      $display("FAIL %s: got acc=%h cy=%b ac=%b expected acc=%h cy=%b ac=%b",
               req, acc_q, cy_q, ac_q, exp[9:2], exp[1], exp[0]);
    end
  endtask

  // drive after a falling edge, result sampled on the next falling edge
  task automatic issue(input logic v, input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic h);
    op_valid = v; op_sel = op; acc_in = a; opnd_in = b; cy_in = c; ac_in = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag(input logic [1:0] op);
    case (op)
      2'b00:   tag = "R2 R3 R4";
      2'b01:   tag = "R5 R3 R4";
      default: tag = "R6 R7 R8";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_err++;
      $display("FAIL watchdog: cycles=%0d expected at most %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [9:0] r;
    logic [9:0] prev;
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 2'b00;
    acc_in = '0; opnd_in = '0; cy_in = 1'b0; ac_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 10'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 10'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][29:28], VEC[i][27:20], VEC[i][19:12], VEC[i][11], VEC[i][10]);
      chk(tag(VEC[i][29:28]), VEC[i][9:0]);
    end

    // R9: idle strobe and no-op code keep the outputs
    issue(1'b1, 2'b00, 8'h19, 8'h28, 1'b0, 1'b0);
    prev = {acc_q, cy_q, ac_q};
    issue(1'b0, 2'b00, 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk("R9 valid low", prev);
    issue(1'b1, 2'b11, 8'hEE, 8'h77, 1'b1, 1'b1);
    chk("R9 code 11", prev);

    // R2 R3: exhaustive add, carry input toggled to show it is ignored
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        issue(1'b1, 2'b00, 8'(a), 8'(b), b[0], a[0]);
        chk("R2 R3 exhaustive add", model(2'b00, 8'(a), 8'(b), 1'b0, 1'b0));
      end
    end

    // R5 R4: add with carry sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) begin
        for (int c = 0; c < 2; c++) begin
          issue(1'b1, 2'b01, 8'(a), 8'(b), c[0], 1'b0);
          chk("R5 R4 add with carry", model(2'b01, 8'(a), 8'(b), c[0], 1'b0));
        end
      end
    end

    // R6 R7 R8: every BCD pair added, then adjusted
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        logic [7:0] bx, by;
        bx = 8'((x / 10) * 16 + (x % 10));
        by = 8'((y / 10) * 16 + (y % 10));
        r = model(2'b00, bx, by, 1'b0, 1'b0);
        issue(1'b1, 2'b00, bx, by, 1'b0, 1'b0);
        chk("R2 BCD add", r);
        issue(1'b1, 2'b10, r[9:2], 8'hA5, r[1], r[0]);
        chk("R6 R7 R8 decimal adjust", model(2'b10, r[9:2], 8'hA5, r[1], r[0]));
      end
    end

    // R1: reset in the middle of operation
    issue(1'b1, 2'b01, 8'hFF, 8'hFF, 1'b1, 1'b0);
    chk("R5 before reset", 10'b1111_1111_1_1);
    op_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset", 10'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after second release", 10'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule